// File: doc/BRIEF.md
# Fast Serial Port Register and Interrupt Interface

This block is the register file that sits between a 32-bit word-addressed read/write bus and the two data paths of a fast serial port. Software reaches five word registers: a data window, a fill-level word, a latched interrupt-status word, a control word and a bit-rate word. Behind the data window are two byte queues of equal depth. Bus writes feed the transmit queue, and the serializer drains it through a take strobe. The deserializer fills the receive queue through a push strobe, and bus reads drain it.

The block turns queue activity into interrupt causes. Some causes are latched and cleared by writing ones to the status word. Others follow the receive queue live. Each cause group has its own enable, and together they drive one interrupt request line. The control word also holds the coded trigger levels, a receive-inactivity timeout, a line-break force bit and a sample-offset field, which is passed out to the deserializer. The rate word sets a bit-tick generator that pulses once every (rate+1) x 14 clock cycles.

A bus access takes one cycle. Read data is combinational from the address. Side effects of a read or write (queue pop, queue push, flag clear, register update) take place at the clock edge that ends the access.

Top module: `sport_regs`

## Requirements
- R1: Word registers decode on address bits 4:2: data at 0x00, level at 0x04, status at 0x08, control at 0x0C, rate at 0x10. After reset, the level, status, control and rate words all read zero, both queues are empty, and `irq`, `tx_valid` and `line_break` are low.
- R2: The level word returns the transmit-queue count in bits 15:8 and the receive-queue count in bits 7:0. Neither count ever exceeds the queue depth (64).
- R3: A data write pushes bits 7:0 into the transmit queue, and the serializer receives the bytes in write order on `tx_byte` while `tx_valid` is high. A data write while the transmit queue holds 64 bytes is dropped.
- R4: A data read pops the receive queue and returns the byte in bits 7:0, its framing-error flag in bit 9 and its break flag in bit 10. A data read of an empty receive queue returns 0x100 (bit 8 set) and pops nothing.
- R5: A receive push while the receive queue holds 64 entries is dropped and latches the overrun cause in status bit 5.
- R6: A push flagged with a framing error latches status bit 3, and a push flagged as break latches status bit 4. Writing 1 to status bit 0, 3, 4 or 5 clears that cause. Writing 0 leaves it unchanged.
- R7: Status bit 0 (transmit cause) latches when a take leaves the transmit queue at or below the transmit trigger level. That level is coded in control bits 1:0 as 0->0, 1->4, 2->8, 3->16 bytes. Writing 1 to status bit 6 also sets it.
- R8: Status bit 1 is high while the receive count is at least the receive trigger level. That level is coded in control bits 4:2 as 0->1, 1->4, 2->8, 3->16, 4->32, 5->48 bytes, and 6 or 7 also select 48.
- R9: Status bit 2 (receive timeout) sets after N idle ticks with a non-empty receive queue and no push or data read. N is coded in control bits 17:16 as 0->never, 1->4, 2->8, 3->16. A push or a data read clears it.
- R10: `irq` is the OR of three gated terms. Bit 1 or bit 2 is gated by the receive enable in control bit 6. Bit 3, 4 or 5 is gated by the error enable in control bit 7. Bit 0 is gated by the transmit enable in control bit 5.
- R11: Control bit 8 drives `line_break`, and control bits 13:9 drive `sample_offset`. Control bits 17:16 and 13:0 read back as written, and all other bits read zero.
- R12: The rate word keeps its low 8 bits, drives `baud_div` and restarts the tick generator when written. `baud_tick` then pulses for one cycle every (rate+1) x 14 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_byte | output | 8 | Byte at the head of the transmit queue |
| tx_take | input | 1 | Serializer pops the transmit head |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | Delivered byte had a framing error |
| rx_break | input | 1 | Delivered byte is a break condition |
| rx_idle_tick | input | 1 | One character time of line idle elapsed |
| line_break | output | 1 | Force break on the transmit line |
| sample_offset | output | 5 | Sample-point offset for the deserializer |
| baud_div | output | RATE_W | Current rate word |
| baud_tick | output | 1 | One-cycle bit-rate pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 64-entry queue depth, a 5-bit address, an 8-bit rate and an oversample factor of 14. With a depth of 64, both queue-full boundaries (the dropped 65th transmit write and the overrun on the 65th receive push) take only a few hundred cycles, and the largest receive trigger of 48 can still be reached. With an 8-bit rate, the longest tick period (256 x 14 cycles) is short enough to measure directly. Random traffic on both queues is checked against queue models for ordering and fill levels. Directed cases cover each trigger coding, the timeout codes, write-one-to-clear and interrupt gating.

// File: rtl/sport_pkg.sv
package sport_pkg;

   localparam logic [2:0] IDX_DATA  = 3'd0;
   localparam logic [2:0] IDX_LEVEL = 3'd1;
   localparam logic [2:0] IDX_STAT  = 3'd2;
   localparam logic [2:0] IDX_CTRL  = 3'd3;
   localparam logic [2:0] IDX_RATE  = 3'd4;

   localparam int unsigned ST_TX    = 0;
   localparam int unsigned ST_TRIG  = 1;
   localparam int unsigned ST_TMO   = 2;
   localparam int unsigned ST_FE    = 3;
   localparam int unsigned ST_BRK   = 4;
   localparam int unsigned ST_OE    = 5;
   localparam int unsigned ST_TXSET = 6;

   typedef struct packed {
      logic [1:0] idle_code;
      logic [4:0] offs;
      logic       brk;
      logic       err_en;
      logic       rx_en;
      logic       tx_en;
      logic [2:0] rx_code;
      logic [1:0] tx_code;
   } ctl_t;

   function automatic logic [31:0] ctl_to_word(input ctl_t c);
      logic [31:0] w;
      w        = '0;
      w[1:0]   = c.tx_code;
      w[4:2]   = c.rx_code;
      w[5]     = c.tx_en;
      w[6]     = c.rx_en;
      w[7]     = c.err_en;
      w[8]     = c.brk;
      w[13:9]  = c.offs;
      w[17:16] = c.idle_code;
      return w;
   endfunction

   function automatic ctl_t word_to_ctl(input logic [31:0] w);
      ctl_t c;
      c.tx_code   = w[1:0];
      c.rx_code   = w[4:2];
      c.tx_en     = w[5];
      c.rx_en     = w[6];
      c.err_en    = w[7];
      c.brk       = w[8];
      c.offs      = w[13:9];
      c.idle_code = w[17:16];
      return c;
   endfunction

   function automatic logic [7:0] rx_trig_bytes(input logic [2:0] code);
      case (code)
         3'd0:    return 8'd1;
         3'd1:    return 8'd4;
         3'd2:    return 8'd8;
         3'd3:    return 8'd16;
         3'd4:    return 8'd32;
         default: return 8'd48;
      endcase
   endfunction

   function automatic logic [7:0] tx_trig_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 8'd0;
         2'd1:    return 8'd4;
         2'd2:    return 8'd8;
         default: return 8'd16;
      endcase
   endfunction

   function automatic logic [7:0] idle_limit(input logic [1:0] code);
      case (code)
         2'd0:    return 8'd0;
         2'd1:    return 8'd4;
         2'd2:    return 8'd8;
         default: return 8'd16;
      endcase
   endfunction

endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned W     = 8,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
      $error("sport_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/sport_idle.sv
module sport_idle
   import sport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] code,
   input  logic       tick,
   input  logic       activity,
   input  logic       has_data,
   output logic       flag
);

   logic [7:0] lim;
   logic [7:0] cnt;

   assign lim = idle_limit(code);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else if (activity || !has_data || lim == 8'd0) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else if (tick && !flag) begin
         cnt <= cnt + 8'd1;
         if (cnt + 8'd1 == lim) flag <= 1'b1;
      end
   end

endmodule

// File: rtl/sport_baud.sv
module sport_baud #(
   parameter int unsigned RATE_W = 8,
   parameter int unsigned OVS    = 14,
   localparam int unsigned PW    = $clog2(OVS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);

   if (OVS < 2) begin : g_ovs_chk
      $error("sport_baud: OVS must be at least 2");
   end

   logic [RATE_W-1:0] pre;
   logic [PW-1:0]     ph;
   logic              pre_wrap, ph_wrap;

   assign pre_wrap = (pre == rate);
   assign ph_wrap  = (ph == PW'(OVS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         pre  <= '0;
         ph   <= '0;
         tick <= 1'b0;
      end else begin
         tick <= pre_wrap & ph_wrap;
         if (pre_wrap) begin
            pre <= '0;
            ph  <= ph_wrap ? '0 : ph + 1'b1;
         end else begin
            pre <= pre + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sport_regs.sv
module sport_regs
   import sport_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 64,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned RATE_W     = 8,
   parameter int unsigned OVERSAMPLE = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   input  logic              tx_take,
   input  logic              rx_push,
   input  logic [7:0]        rx_byte,
   input  logic              rx_frame_err,
   input  logic              rx_break,
   input  logic              rx_idle_tick,
   output logic              line_break,
   output logic [4:0]        sample_offset,
   output logic [RATE_W-1:0] baud_div,
   output logic              baud_tick,
   output logic              irq
);

   localparam int unsigned CW    = $clog2(FIFO_DEPTH + 1);
   localparam int unsigned RXE_W = 10;

   if (FIFO_DEPTH < 48 || FIFO_DEPTH > 255) begin : g_depth_chk
      $error("sport_regs: FIFO_DEPTH must lie in 48..255");
   end
   if (ADDR_W < 5) begin : g_addr_chk
      $error("sport_regs: ADDR_W must be at least 5");
   end
   if (RATE_W < 1 || RATE_W > 16) begin : g_rate_chk
      $error("sport_regs: RATE_W must lie in 1..16");
   end

   // ---------------- address decode ----------------
   logic       upper_ok;
   logic [2:0] widx;
   logic       acc_wr, acc_rd;
   logic       wr_data, wr_stat, wr_ctrl, wr_rate, rd_data;
   logic       unused_in;

   if (ADDR_W > 5) begin : g_upper
      assign upper_ok = (bus_addr[ADDR_W-1:5] == '0);
   end else begin : g_flat
      assign upper_ok = 1'b1;
   end

   assign widx      = bus_addr[4:2];
   assign acc_wr    = bus_sel & bus_wr & upper_ok;
   assign acc_rd    = bus_sel & ~bus_wr & upper_ok;
   assign wr_data   = acc_wr & (widx == IDX_DATA);
   assign wr_stat   = acc_wr & (widx == IDX_STAT);
   assign wr_ctrl   = acc_wr & (widx == IDX_CTRL);
   assign wr_rate   = acc_wr & (widx == IDX_RATE);
   assign rd_data   = acc_rd & (widx == IDX_DATA);
   assign unused_in = ^{bus_wdata, bus_addr[1:0]};

   // ---------------- queues ----------------
   logic [CW-1:0]    tx_cnt, rx_cnt;
   logic             tx_full, tx_empty, rx_full, rx_empty;
   logic [RXE_W-1:0] rx_head;

   sport_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_data),
      .din   (bus_wdata[7:0]),
      .pop   (tx_take),
      .dout  (tx_byte),
      .count (tx_cnt),
      .full  (tx_full),
      .empty (tx_empty)
   );

   sport_fifo #(.DEPTH(FIFO_DEPTH), .W(RXE_W)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .din   ({rx_break, rx_frame_err, rx_byte}),
      .pop   (rd_data),
      .dout  (rx_head),
      .count (rx_cnt),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign tx_valid = ~tx_empty;

   // ---------------- control and rate ----------------
   ctl_t              ctl;
   logic [RATE_W-1:0] rate_q;
   logic              en_tx, en_rx, en_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl    <= '0;
         rate_q <= '0;
      end else begin
         if (wr_ctrl) ctl    <= word_to_ctl(bus_wdata);
         if (wr_rate) rate_q <= bus_wdata[RATE_W-1:0];
      end
   end

   assign en_tx         = ctl.tx_en;
   assign en_rx         = ctl.rx_en;
   assign en_err        = ctl.err_en;
   assign line_break    = ctl.brk;
   assign sample_offset = ctl.offs;
   assign baud_div      = rate_q;

   sport_baud #(.RATE_W(RATE_W), .OVS(OVERSAMPLE)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_rate),
      .rate    (rate_q),
      .tick    (baud_tick)
   );

   // ---------------- interrupt causes ----------------
   logic st_tx, st_fe, st_brk, st_oe, st_tmo;
   logic rx_trig_now, tx_low_evt;

   assign rx_trig_now = (8'(rx_cnt) >= rx_trig_bytes(ctl.rx_code));
   assign tx_low_evt  = tx_take & ~tx_empty &
                        ((8'(tx_cnt) - 8'd1) <= tx_trig_bytes(ctl.tx_code));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_tx  <= 1'b0;
         st_fe  <= 1'b0;
         st_brk <= 1'b0;
         st_oe  <= 1'b0;
      end else begin
         if (wr_stat && bus_wdata[ST_TX])  st_tx  <= 1'b0;
         if (wr_stat && bus_wdata[ST_FE])  st_fe  <= 1'b0;
         if (wr_stat && bus_wdata[ST_BRK]) st_brk <= 1'b0;
         if (wr_stat && bus_wdata[ST_OE])  st_oe  <= 1'b0;
         if (tx_low_evt || (wr_stat && bus_wdata[ST_TXSET])) st_tx <= 1'b1;
         if (rx_push && rx_frame_err) st_fe  <= 1'b1;
         if (rx_push && rx_break)     st_brk <= 1'b1;
         if (rx_push && rx_full)      st_oe  <= 1'b1;
      end
   end

   sport_idle u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (ctl.idle_code),
      .tick     (rx_idle_tick),
      .activity (rx_push | rd_data),
      .has_data (~rx_empty),
      .flag     (st_tmo)
   );

   assign irq = (en_rx  & (rx_trig_now | st_tmo)) |
                (en_err & (st_fe | st_brk | st_oe)) |
                (en_tx  & st_tx);

   // ---------------- read mux ----------------
   logic [31:0] rmux;
   always_comb begin
      rmux = '0;
      case (widx)
         IDX_DATA:  rmux = rx_empty ? 32'h0000_0100
                                    : {21'b0, rx_head[9:8], 1'b0, rx_head[7:0]};
         IDX_LEVEL: rmux = {16'b0, 8'(tx_cnt), 8'(rx_cnt)};
         IDX_STAT:  rmux = {26'b0, st_oe, st_brk, st_fe, st_tmo, rx_trig_now, st_tx};
         IDX_CTRL:  rmux = ctl_to_word(ctl);
         IDX_RATE:  rmux = {{(32-RATE_W){1'b0}}, rate_q};
         default:   rmux = '0;
      endcase
   end

   assign bus_rdata = acc_rd ? rmux : 32'h0;

endmodule

// File: rtl/sport_regs_chk.sv
module sport_regs_chk #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned ADDR_W = 5,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              rx_push,
   input logic              tx_take,
   input logic              irq,
   input logic              baud_tick,
   input logic [CW-1:0]     tx_cnt,
   input logic [CW-1:0]     rx_cnt,
   input logic              st_fe,
   input logic              st_oe,
   input logic              en_tx,
   input logic              en_rx,
   input logic              en_err
);

   localparam logic [ADDR_W-3:0] W_DATA = '0;
   localparam logic [ADDR_W-3:0] W_STAT = 2;

   logic hit_data_wr, hit_data_rd, hit_stat_wr;
   assign hit_data_wr = bus_sel & bus_wr  & (bus_addr[ADDR_W-1:2] == W_DATA);
   assign hit_data_rd = bus_sel & ~bus_wr & (bus_addr[ADDR_W-1:2] == W_DATA);
   assign hit_stat_wr = bus_sel & bus_wr  & (bus_addr[ADDR_W-1:2] == W_STAT);

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)))
      else $error("count above depth");

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_data_wr && tx_cnt == CW'(DEPTH) && !tx_take) |=> $stable(tx_cnt))
      else $error("write into full transmit queue changed the count");

   p_rx_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_data_rd && rx_cnt != '0 && !rx_push) |=> (rx_cnt == $past(rx_cnt) - 1'b1))
      else $error("data read did not pop one entry");

   p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_cnt == CW'(DEPTH)) |=> st_oe)
      else $error("overrun cause not latched");

   p_w1c_fe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stat_wr && bus_wdata[3] && !rx_push) |=> !st_fe)
      else $error("framing cause survived its clear");

   p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_tx && !en_rx && !en_err) |-> !irq)
      else $error("interrupt raised with all enables off");

   p_tick_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |=> !baud_tick)
      else $error("bit tick wider than one cycle");

endmodule

bind sport_regs sport_regs_chk #(.DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .rx_push   (rx_push),
   .tx_take   (tx_take),
   .irq       (irq),
   .baud_tick (baud_tick),
   .tx_cnt    (tx_cnt),
   .rx_cnt    (rx_cnt),
   .st_fe     (st_fe),
   .st_oe     (st_oe),
   .en_tx     (en_tx),
   .en_rx     (en_rx),
   .en_err    (en_err)
);

// File: tb/sim_sport_regs.sv
`timescale 1ns/1ps
module sim_sport_regs;

   localparam int DEPTH = 64;
   localparam logic [4:0] A_DATA = 5'h00, A_LVL = 5'h04, A_ST = 5'h08,
                          A_CTL = 5'h0C, A_RATE = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 0, bus_wr = 0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_valid, tx_take = 0;
   logic [7:0]  tx_byte;
   logic        rx_push = 0, rx_frame_err = 0, rx_break = 0, rx_idle_tick = 0;
   logic [7:0]  rx_byte = '0;
   logic        line_break, baud_tick, irq;
   logic [4:0]  sample_offset;
   logic [7:0]  baud_div;

   int tests = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sport_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_take(tx_take),
      .rx_push(rx_push), .rx_byte(rx_byte), .rx_frame_err(rx_frame_err),
      .rx_break(rx_break), .rx_idle_tick(rx_idle_tick),
      .line_break(line_break), .sample_offset(sample_offset),
      .baud_div(baud_div), .baud_tick(baud_tick), .irq(irq)
   );

   function automatic logic [31:0] lvl_word(input int txn, input int rxn);
      return {16'b0, 8'(txn), 8'(rxn)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic push_rx(input logic [7:0] b, input logic fe, input logic bk);
      rx_push = 1; rx_byte = b; rx_frame_err = fe; rx_break = bk;
      @(posedge clk); @(negedge clk);
      rx_push = 0; rx_frame_err = 0; rx_break = 0;
   endtask

   task automatic take_tx(output logic [7:0] b);
      b = tx_byte; tx_take = 1;
      @(posedge clk); @(negedge clk);
      tx_take = 0;
   endtask

   task automatic idle_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         rx_idle_tick = 1; @(posedge clk); @(negedge clk); rx_idle_tick = 0;
      end
   endtask

   task automatic measure_period(output int n);
      int guard = 0;
      while (!baud_tick && guard < 5000) begin @(negedge clk); guard++; end
      n = 0;
      do begin @(negedge clk); n++; end while (!baud_tick && n < 5000);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  b;
      int          per;
      logic [7:0]  txq[$];
      logic [7:0]  rxq[$];

      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1 reset state
      rd(A_LVL, d);  chk("R1 level", d, 0);
      rd(A_ST, d);   chk("R1 status", d, 0);
      rd(A_CTL, d);  chk("R1 control", d, 0);
      rd(A_RATE, d); chk("R1 rate", d, 0);
      chk("R1 outputs", {29'b0, irq, tx_valid, line_break}, 0);
      // R4 empty read returns 0x100 and pops nothing
      rd(A_DATA, d); chk("R4 empty read", d, 32'h100);
      rd(A_LVL, d);  chk("R4 empty read no pop", d, 0);

      // R3 fill transmit queue, 65th write dropped; R7 threshold 0
      for (int i = 0; i < DEPTH + 1; i++) wr(A_DATA, 32'((i * 3 + 1) & 8'hFF));
      rd(A_LVL, d); chk("R2 R3 tx full level", d, lvl_word(DEPTH, 0));
      chk("R3 tx_valid", {31'b0, tx_valid}, 1);
      for (int i = 0; i < DEPTH - 1; i++) begin
         take_tx(b); chk("R3 tx order", {24'b0, b}, 32'((i * 3 + 1) & 8'hFF));
      end
      rd(A_ST, d); chk("R7 not yet low", d & 1, 0);
      take_tx(b); chk("R3 tx last", {24'b0, b}, 32'(((DEPTH - 1) * 3 + 1) & 8'hFF));
      rd(A_ST, d); chk("R7 empty sets tx cause", d & 1, 1);
      wr(A_ST, 32'h0); rd(A_ST, d); chk("R6 zero write keeps", d & 1, 1);
      wr(A_ST, 32'h1); rd(A_ST, d); chk("R6 clear tx cause", d & 1, 0);

      // R7 threshold 16
      wr(A_CTL, 32'h3);
      for (int i = 0; i < 20; i++) wr(A_DATA, 32'(i));
      for (int i = 0; i < 3; i++) take_tx(b);
      rd(A_ST, d); chk("R7 17 left", d & 1, 0);
      take_tx(b);
      rd(A_ST, d); chk("R7 16 left", d & 1, 1);
      for (int i = 0; i < 16; i++) take_tx(b);
      wr(A_ST, 32'h1);
      wr(A_ST, 32'h40); rd(A_ST, d); chk("R7 software set", d & 1, 1);
      wr(A_ST, 32'h1);

      // R8 receive trigger code 2 (8 bytes) and code 6 (48)
      wr(A_CTL, 32'h8);
      for (int i = 0; i < 7; i++) push_rx(8'(i), 0, 0);
      rd(A_ST, d); chk("R8 seven below 8", d & 2, 0);
      push_rx(8'h7, 0, 0);
      rd(A_ST, d); chk("R8 eight reaches 8", d & 2, 2);
      rd(A_DATA, d); chk("R4 pop first", d, 0);
      rd(A_ST, d); chk("R8 drops below", d & 2, 0);
      for (int i = 0; i < 7; i++) rd(A_DATA, d);
      wr(A_CTL, 32'h18);
      for (int i = 0; i < 47; i++) push_rx(8'(i), 0, 0);
      rd(A_ST, d); chk("R8 47 below 48", d & 2, 0);
      push_rx(8'h2F, 0, 0);
      rd(A_ST, d); chk("R8 48 reaches", d & 2, 2);
      for (int i = 0; i < 48; i++) rd(A_DATA, d);

      // R5 overrun
      wr(A_CTL, 32'h0);
      for (int i = 0; i < DEPTH + 1; i++) push_rx(8'(i + 100), 0, 0);
      rd(A_ST, d);  chk("R5 overrun latched", d & 32'h20, 32'h20);
      rd(A_LVL, d); chk("R2 rx full level", d, lvl_word(0, DEPTH));
      for (int i = 0; i < DEPTH; i++) begin
         rd(A_DATA, d); chk("R5 rx order", d, 32'((i + 100) & 8'hFF));
      end
      rd(A_DATA, d); chk("R5 extra dropped", d, 32'h100);
      wr(A_ST, 32'h20); rd(A_ST, d); chk("R6 clear overrun", d, 0);

      // R6 framing and break
      push_rx(8'hA5, 1, 0);
      rd(A_ST, d); chk("R6 framing latched", d & 32'h18, 32'h08);
      push_rx(8'h5A, 0, 1);
      rd(A_ST, d); chk("R6 break latched", d & 32'h18, 32'h18);
      wr(A_ST, 32'h0); rd(A_ST, d); chk("R6 zero keeps errors", d & 32'h18, 32'h18);
      rd(A_DATA, d); chk("R4 error flag bit9", d, 32'h2A5);
      rd(A_DATA, d); chk("R4 break flag bit10", d, 32'h45A);
      wr(A_ST, 32'h18); rd(A_ST, d); chk("R6 clear errors", d & 32'h18, 0);

      // R9 receive timeout
      wr(A_CTL, 32'h1_0000);
      push_rx(8'h11, 0, 0);
      idle_ticks(3); rd(A_ST, d); chk("R9 3 of 4 ticks", d & 4, 0);
      idle_ticks(1); rd(A_ST, d); chk("R9 4 ticks", d & 4, 4);
      rd(A_DATA, d); rd(A_ST, d); chk("R9 read clears", d & 4, 0);
      wr(A_CTL, 32'h3_0000);
      push_rx(8'h22, 0, 0);
      idle_ticks(15); rd(A_ST, d); chk("R9 15 of 16 ticks", d & 4, 0);
      idle_ticks(1);  rd(A_ST, d); chk("R9 16 ticks", d & 4, 4);
      push_rx(8'h23, 0, 0); rd(A_ST, d); chk("R9 push clears", d & 4, 0);
      rd(A_DATA, d); rd(A_DATA, d);
      wr(A_CTL, 32'h0);
      push_rx(8'h33, 0, 0);
      idle_ticks(20); rd(A_ST, d); chk("R9 disabled", d & 4, 0);
      rd(A_DATA, d);

      // R10 interrupt gating
      wr(A_ST, 32'h40);
      chk("R10 tx masked", {31'b0, irq}, 0);
      wr(A_CTL, 32'h20); chk("R10 tx enabled", {31'b0, irq}, 1);
      wr(A_ST, 32'h1);   chk("R10 tx cleared", {31'b0, irq}, 0);
      push_rx(8'h44, 1, 0);
      chk("R10 error under tx enable", {31'b0, irq}, 0);
      wr(A_CTL, 32'h80); chk("R10 error enabled", {31'b0, irq}, 1);
      wr(A_ST, 32'h8);   chk("R10 error cleared", {31'b0, irq}, 1'b0);
      wr(A_CTL, 32'h40); chk("R10 rx trigger", {31'b0, irq}, 1);
      rd(A_DATA, d);     chk("R10 rx drained", {31'b0, irq}, 0);

      // R11 control readback and outputs
      wr(A_CTL, 32'hFFFF_FFFF);
      rd(A_CTL, d); chk("R11 readback mask", d, 32'h0003_3FFF);
      wr(A_CTL, (32'd1 << 8) | (32'd21 << 9));
      chk("R11 line_break", {31'b0, line_break}, 1);
      chk("R11 sample_offset", {27'b0, sample_offset}, 21);
      wr(A_CTL, 32'h0);
      chk("R11 line_break off", {31'b0, line_break}, 0);

      // R12 rate and tick period
      wr(A_RATE, 32'h1FF);
      rd(A_RATE, d); chk("R12 rate width", d, 32'hFF);
      chk("R12 baud_div", {24'b0, baud_div}, 32'hFF);
      measure_period(per); chk("R12 period 255", 32'(per), 256 * 14);
      wr(A_RATE, 32'd2);
      measure_period(per); chk("R12 period 2", 32'(per), 42);
      wr(A_RATE, 32'd0);
      measure_period(per); chk("R12 period 0", 32'(per), 14);

      // Random traffic on both queues (R2 R3 R4)
      void'($urandom(32'd2718));
      for (int n = 0; n < 800; n++) begin
         int op;
         logic [7:0] rb;
         op = int'($urandom % 4);
         rb = 8'($urandom);
         case (op)
            0: begin
               wr(A_DATA, {24'b0, rb});
               if (txq.size() < DEPTH) txq.push_back(rb);
            end
            1: if (txq.size() > 0) begin
               take_tx(b); chk("R3 random tx order", {24'b0, b}, {24'b0, txq.pop_front()});
            end
            2: begin
               push_rx(rb, 0, 0);
               if (rxq.size() < DEPTH) rxq.push_back(rb);
            end
            default: begin
               rd(A_DATA, d);
               if (rxq.size() > 0) chk("R4 random rx data", d, {24'b0, rxq.pop_front()});
               else chk("R4 random empty read", d, 32'h100);
            end
         endcase
         if (n % 25 == 0) begin
            rd(A_LVL, d); chk("R2 random level", d, lvl_word(txq.size(), rxq.size()));
         end
      end
      rd(A_LVL, d); chk("R2 final level", d, lvl_word(txq.size(), rxq.size()));

      finish_run();
   end

endmodule